// File: doc/BRIEF.md
# Stepped Transmit Gain Controller

This block is the digital decision core of a transmit automatic level control loop. It holds a 5-bit gain step index that drives an external variable-gain amplifier with 32 steps of roughly 1 dB each, spanning about 0 to 30 dB. The index moves by at most one step per update tick. The tick is a slow strobe, nominally 5 kHz, generated elsewhere.

Two comparator pairs feed the block. One pair watches the peak output voltage and the other watches the peak output current. Each pair reports whether the sensed level is below its lower threshold or above its upper threshold. The voltage pair steers the gain up or down toward its hysteresis band. The current pair acts as a limiter with priority over the voltage pair: it can pull the gain down, freeze it, or leave the decision to the voltage pair.

While transmit is disabled the index rests at mid-scale, so each transmit session starts stepping from step 16.

Top module: `tx_gain_stepper`

## Requirements
- R1: After reset the gain index output is 16.
- R2: While `tx_en` is 0 at a clock edge, the index becomes 16 after that edge, and ticks and flags have no effect.
- R3: With `tx_en` at 1 and `tick` at 0, the index does not change.
- R4: On a tick with `tx_en` at 1 and `cur_high` at 1, the index drops by one step, whatever the voltage flags are.
- R5: On a tick with `tx_en` at 1 and both current flags at 0 (current inside its band), the index is unchanged, even if `volt_low` is 1.
- R6: On a tick with `tx_en` at 1, `cur_low` at 1, `cur_high` at 0, `volt_low` at 1 and `volt_high` at 0, the index rises by one step.
- R7: On a tick with `tx_en` at 1, `cur_low` at 1, `cur_high` at 0 and both voltage flags at 0, the index is unchanged.
- R8: On a tick with `tx_en` at 1, `cur_low` at 1, `cur_high` at 0 and `volt_high` at 1, the index drops by one step.
- R9: The index saturates. A decrease at 0 leaves it at 0, and an increase at 31 leaves it at 31. It never wraps around.
- R10: If a comparator pair reports both low and high at once, that pair is treated as above its upper threshold.
- R11: When `tx_en` rises after a session, the first tick steps from 16. For example, one raising tick gives 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit session active |
| tick | input | 1 | Single-cycle gain update strobe |
| volt_low | input | 1 | Voltage peak below lower threshold |
| volt_high | input | 1 | Voltage peak above upper threshold |
| cur_low | input | 1 | Current peak below lower threshold |
| cur_high | input | 1 | Current peak above upper threshold |
| gain_idx | output | 5 | Gain step index, 0 to 31 |

## Verification
The two loops meet in the same tick: a voltage request to raise the gain can coincide with a current flag that lowers or freezes it. Saturation can also coincide with a step request. The bench drives all four flags at random on random ticks, so the voltage-raise and current-limit cases collide often. Directed runs push the index into both rails while the opposing loop is still requesting. Each result is judged against a bench model that applies current priority first, then the voltage loop, then clamping to 0 and 31.

// File: rtl/tx_gain_stepper.sv
module tx_gain_stepper #(
  parameter int IDX_W = 5,
  parameter int START = 2 ** (IDX_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tick,
  input  logic             volt_low,
  input  logic             volt_high,
  input  logic             cur_low,
  input  logic             cur_high,
  output logic [IDX_W-1:0] gain_idx
);

  localparam logic [IDX_W-1:0] TOP  = '1;
  localparam logic [IDX_W-1:0] MIDV = IDX_W'(START);

  logic cur_over, cur_band, v_over, v_under;
  logic want_up, want_dn;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign cur_over = cur_high;
  assign cur_band = !cur_high && !cur_low;
  assign v_over   = volt_high;
  assign v_under  = volt_low && !volt_high;

  assign want_dn = cur_over || (!cur_band && v_over);
  assign want_up = !cur_over && !cur_band && v_under;

  always_comb begin
    idx_d = idx_q;
    if (!tx_en)
      idx_d = MIDV;
    else if (tick) begin
      if (want_dn && idx_q != '0)
        idx_d = idx_q - 1'b1;
      else if (want_up && idx_q != TOP)
        idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idx_q <= MIDV;
    else        idx_q <= idx_d;

  assign gain_idx = idx_q;

  // R2
  idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> gain_idx == MIDV);

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tick) |=> $stable(gain_idx));

  // R4
  cur_over_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && cur_high && gain_idx != '0) |=> gain_idx == $past(gain_idx) - 1'b1);

  // R5
  cur_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && !cur_high && !cur_low) |=> $stable(gain_idx));

  // R6
  volt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && cur_low && !cur_high && volt_low && !volt_high && gain_idx != TOP)
      |=> gain_idx == $past(gain_idx) + 1'b1);

  // R9
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && cur_high && gain_idx == '0) |=> gain_idx == '0);

  // R9
  ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tick && gain_idx == TOP) |=> gain_idx != '0);

endmodule

// File: tb/test_tx_gain_stepper.sv
module test_tx_gain_stepper;
  logic clk = 0, rst_n = 0;
  logic tx_en = 0, tick = 0, volt_low = 0, volt_high = 0, cur_low = 0, cur_high = 0;
  logic [4:0] gain_idx;
  int checks = 0, errors = 0;
  bit done = 0;
  int exp_idx;

  always #10 clk = ~clk;

  tx_gain_stepper i_tx_gain_stepper (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tick),
    .volt_low(volt_low), .volt_high(volt_high),
    .cur_low(cur_low), .cur_high(cur_high), .gain_idx(gain_idx));

  function automatic int model(int cur, bit en, bit tk, bit vl, bit vh, bit cl, bit ch);
    int delta = 0;
    if (!en) return 16;
    if (!tk) return cur;
    if (ch) delta = -1;
    else if (!cl) delta = 0;
    else if (vh) delta = -1;
    else if (vl) delta = 1;
    cur = cur + delta;
    if (cur < 0) cur = 0;
    if (cur > 31) cur = 31;
    return cur;
  endfunction

  function automatic string rule(bit en, bit tk, bit vl, bit vh, bit cl, bit ch);
    if (!en) return "R2";
    if (!tk) return "R3";
    if (ch) return (cl ? "R10" : "R4");
    if (!cl) return "R5";
    if (vh) return (vl ? "R10" : "R8");
    if (vl) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, int expv);
    checks++;
    if (int'(gain_idx) != expv) begin
      errors++;
      $display("FAIL %s: gain_idx=%0d expected=%0d", req, gain_idx, expv);
    end
  endtask

  task automatic step(bit en, bit tk, bit vl, bit vh, bit cl, bit ch);
    @(negedge clk);
    tx_en = en; tick = tk; volt_low = vl; volt_high = vh; cur_low = cl; cur_high = ch;
    exp_idx = model(exp_idx, en, tk, vl, vh, cl, ch);
    @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: gain_idx=%0d expected=done", gain_idx);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_idx = 16;
    repeat (3) @(negedge clk);
    check("R1", 16);
    rst_n = 1;
    @(negedge clk);
    check("R1", 16);

    // R6 up to ceiling, R9 saturation at 31
    for (int k = 0; k < 20; k++) step(1, 1, 1, 0, 1, 0);
    check("R9", 31);
    step(1, 1, 1, 0, 1, 0);
    check("R9", 31);
    // R5: current in band blocks raise
    step(1, 1, 1, 0, 0, 0);
    check("R5", 31);
    // R4: current over overrides voltage raise
    step(1, 1, 1, 0, 1, 1);
    check("R10", 30);
    step(1, 1, 1, 0, 0, 1);
    check("R4", 29);
    for (int k = 0; k < 40; k++) step(1, 1, 1, 0, 0, 1);
    check("R9", 0);
    step(1, 1, 0, 1, 1, 0);
    check("R9", 0);
    // R3: no tick, no change
    step(1, 0, 1, 0, 1, 0);
    check("R3", 0);
    // R2: disabled forces mid and ignores tick
    step(0, 1, 1, 0, 1, 0);
    check("R2", 16);
    step(0, 1, 0, 0, 0, 1);
    check("R2", 16);
    // R11: new session starts from 16
    step(1, 1, 1, 0, 1, 0);
    check("R11", 17);
    // R8 and R7
    step(1, 1, 0, 1, 1, 0);
    check("R8", 16);
    step(1, 1, 0, 0, 1, 0);
    check("R7", 16);
    // R10 voltage pair both set
    step(1, 1, 1, 1, 1, 0);
    check("R10", 15);

    for (int n = 0; n < 4000; n++) begin
      bit en, tk, vl, vh, cl, ch;
      en = ($urandom % 20) != 0;
      tk = ($urandom % 3) == 0;
      vl = $urandom % 2; vh = $urandom % 2;
      cl = $urandom % 2; ch = ($urandom % 3) == 0;
      step(en, tk, vl, vh, cl, ch);
      check(rule(en, tk, vl, vh, cl, ch), exp_idx);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule